// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block is a cycle-based digital model of a clock output stage with per-section skew. It runs on a fast tick clock in which one tick is one time unit. An internal phase counter wraps every N ticks, and this sets the nominal output period. N is picked by a three-level range input. The outputs are grouped into four sections of two identical outputs each. Each section takes two three-level function codes, which select a signed shift in whole ticks, a divide-by-2 or divide-by-4 waveform, or an inverted copy.

A three-level test input can switch the block to bypass. In bypass the tick generator no longer shapes the outputs. Every output follows the reference input level, with its own section's divide or invert function still applied. All three-level inputs arrive as 2-bit codes: 00 LOW, 01 MID, 10 HIGH. Code 11 is read as MID, the same as an open pin.

A change to the range or to any function selection restarts the timing from phase zero. The outputs then stay low for one full period, which is also what happens after reset.

Top module: `skew_clk_matrix`

## Requirements
- R1: With every section at MID/MID, each output has period N ticks and is high for N/2 of them. N is 44 for range code 00, 26 for code 01 and 16 for code 10.
- R2: Sections 0 and 1 take a signed shift from (sel1, sel0) levels: LL −4, LM −3, LH −2, ML −1, MM 0, MH +1, HL +2, HM +3, HH +4. A nominal output is high while ((phase − shift) mod N) < N/2, so a positive shift delays the output.
- R3: Sections 2 and 3 shift by LM −6, LH −4, ML −2, MM 0, MH +2, HL +4, HM +6 ticks.
- R4: On sections 2 and 3, LL gives divide-by-2, and HH on section 2 gives divide-by-4. Both come from one 2-bit divide counter, which steps when the unshifted phase wraps. The ÷2 output is counter bit 0 and the ÷4 output is bit 1, so every falling edge of a ÷4 output lands on a falling edge of a ÷2 output.
- R5: HH on section 3 gives the zero-shift waveform inverted. HH on any other section never inverts.
- R6: The two outputs of a section, q_out[2s] and q_out[2s+1], are always equal.
- R7: When test_sel decodes to MID or HIGH, a shift-mode output equals ref_in from the previous cycle, shifts are ignored, and an inverting output gives its complement.
- R8: In bypass, the divide counter steps on each rising edge of ref_in and not on phase wraps.
- R9: After reset, and after any change of the decoded range or function levels, the phase and divide counters restart at zero and all outputs stay low for the next N cycles.
- R10: Code 11 on any three-level input acts as MID. Moving between 01 and 11 is not a change and does not restart the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per time unit |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 2 | Three-level range code that sets N |
| test_sel | input | 2 | Three-level bypass code; LOW gives normal operation |
| ref_in | input | 1 | Reference level used in bypass |
| func_sel | input | 16 | Per section s: bits [4s+3:4s+2] sel1 code, [4s+1:4s] sel0 code |
| q_out | output | 8 | Section s drives bits 2s and 2s+1 |

## Verification
A wrong phase count or shift decode shows as an edge that lands a few ticks early or late. It can be seen within one period, at most 44 cycles. A wrong divide counter only shows on the divided outputs, and it takes up to four periods for their edge pattern to drift from the expected one. A missed or false restart shows during the hold window that should follow a configuration change, as outputs that are high when they should be low, or the reverse. Comparing the outputs every cycle against a reference model catches each of these at the first cycle where they differ.

// File: rtl/skm_pkg.sv
package skm_pkg;
  typedef enum logic [1:0] {
    LV_LO  = 2'd0,
    LV_MID = 2'd1,
    LV_HI  = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    OM_SHIFT = 2'd0,
    OM_DIV2  = 2'd1,
    OM_DIV4  = 2'd2,
    OM_INV   = 2'd3
  } omode_e;

  localparam int SHW = 4;

  // the unused code behaves like an open pin
  function automatic lvl_e norm_lvl(input logic [1:0] code);
    case (code)
      2'b00:   return LV_LO;
      2'b10:   return LV_HI;
      default: return LV_MID;
    endcase
  endfunction
endpackage

// File: rtl/skm_sel_decode.sv
module skm_sel_decode
  import skm_pkg::*;
#(
  parameter bit WIDE   = 1'b0,
  parameter bit HH_INV = 1'b0
) (
  input  logic [1:0]            sel1_code,
  input  logic [1:0]            sel0_code,
  output omode_e                mode,
  output logic signed [SHW-1:0] shift
);
  logic [3:0]        idx;
  logic signed [4:0] rel;
  logic signed [4:0] dbl;

  always_comb begin
    idx = 4'(2'(norm_lvl(sel1_code))) * 4'd3 + 4'(2'(norm_lvl(sel0_code)));
    rel = $signed({1'b0, idx}) - 5'sd4;
    dbl = rel <<< 1;
    mode  = OM_SHIFT;
    shift = '0;
    if (WIDE) begin
      if (idx == 4'd0) begin
        mode = OM_DIV2;
      end else if (idx == 4'd8) begin
        mode = HH_INV ? OM_INV : OM_DIV4;
      end else begin
        shift = dbl[SHW-1:0];
      end
    end else begin
      shift = rel[SHW-1:0];
    end
  end
endmodule

// File: rtl/skm_timebase.sv
module skm_timebase
  import skm_pkg::*;
#(
  parameter int N_LO  = 44,
  parameter int N_MID = 26,
  parameter int N_HI  = 16,
  parameter int PW    = 6,
  parameter int KW    = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    range_code,
  input  logic [KW-1:0] cfg_key,
  input  logic          bypass,
  input  logic          ref_in,
  output logic [PW-1:0] ph,
  output logic [PW-1:0] nper,
  output logic [1:0]    dcnt,
  output logic          out_en
);
  logic [KW-1:0] key_q;
  logic [PW-1:0] hcnt;
  logic          ref_q;
  logic          restart;
  logic          wrap;
  logic          step;

  always_comb begin
    case (norm_lvl(range_code))
      LV_LO:   nper = PW'(N_LO);
      LV_HI:   nper = PW'(N_HI);
      default: nper = PW'(N_MID);
    endcase
    restart = (cfg_key != key_q);
    wrap    = (ph == nper - PW'(1));
    step    = bypass ? (ref_in & ~ref_q) : wrap;
    out_en  = (hcnt == nper) && !restart;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= '0;
      dcnt  <= '0;
      hcnt  <= '0;
      ref_q <= 1'b0;
      key_q <= cfg_key;
    end else begin
      ref_q <= ref_in;
      if (restart) begin
        ph    <= '0;
        dcnt  <= '0;
        hcnt  <= '0;
        key_q <= cfg_key;
      end else begin
        ph <= wrap ? '0 : ph + PW'(1);
        if (step) dcnt <= dcnt + 2'd1;
        if (hcnt != nper) hcnt <= hcnt + PW'(1);
      end
    end
  end
endmodule

// File: rtl/skm_section_out.sv
module skm_section_out
  import skm_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  omode_e                mode,
  input  logic signed [SHW-1:0] shift,
  input  logic [PW-1:0]         ph,
  input  logic [PW-1:0]         nper,
  input  logic [1:0]            dcnt,
  input  logic                  bypass,
  input  logic                  ref_in,
  input  logic                  out_en,
  output logic [1:0]            q
);
  int   t;
  logic nom;
  logic wave;

  always_comb begin
    t = int'(ph) + int'(nper) - int'(shift);
    if (t >= 2 * int'(nper)) t = t - 2 * int'(nper);
    else if (t >= int'(nper)) t = t - int'(nper);
    nom = bypass ? ref_in : (t < int'(nper) / 2);
    case (mode)
      OM_DIV2: wave = dcnt[0];
      OM_DIV4: wave = dcnt[1];
      OM_INV:  wave = ~nom;
      default: wave = nom;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= out_en ? {2{wave}} : 2'b00;
  end
endmodule

// File: rtl/skew_clk_matrix.sv
module skew_clk_matrix
  import skm_pkg::*;
#(
  parameter int N_LO    = 44,
  parameter int N_MID   = 26,
  parameter int N_HI    = 16,
  parameter int NUM_SEC = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             range_sel,
  input  logic [1:0]             test_sel,
  input  logic                   ref_in,
  input  logic [4*NUM_SEC-1:0]   func_sel,
  output logic [2*NUM_SEC-1:0]   q_out
);
  localparam int N_MAX = (N_LO > N_MID) ? ((N_LO > N_HI) ? N_LO : N_HI)
                                        : ((N_MID > N_HI) ? N_MID : N_HI);
  localparam int PW = $clog2(N_MAX + 1);
  localparam int KW = 2 + 4 * NUM_SEC;

  logic [KW-1:0] cfg_key;
  logic [PW-1:0] ph;
  logic [PW-1:0] nper;
  logic [1:0]    dcnt;
  logic          out_en;
  logic          bypass;

  assign bypass          = (norm_lvl(test_sel) != LV_LO);
  assign cfg_key[KW-1 -: 2] = 2'(norm_lvl(range_sel));

  skm_timebase #(
    .N_LO(N_LO), .N_MID(N_MID), .N_HI(N_HI), .PW(PW), .KW(KW)
  ) u_tb (
    .clk(clk), .rst(rst), .range_code(range_sel), .cfg_key(cfg_key),
    .bypass(bypass), .ref_in(ref_in), .ph(ph), .nper(nper),
    .dcnt(dcnt), .out_en(out_en)
  );

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    omode_e                mode;
    logic signed [SHW-1:0] shift;

    assign cfg_key[4*s +: 4] = {2'(norm_lvl(func_sel[4*s+2 +: 2])),
                                2'(norm_lvl(func_sel[4*s +: 2]))};

    skm_sel_decode #(
      .WIDE(s >= NUM_SEC / 2),
      .HH_INV(s == NUM_SEC - 1)
    ) u_dec (
      .sel1_code(func_sel[4*s+2 +: 2]),
      .sel0_code(func_sel[4*s +: 2]),
      .mode(mode),
      .shift(shift)
    );

    skm_section_out #(.PW(PW)) u_out (
      .clk(clk), .rst(rst), .mode(mode), .shift(shift), .ph(ph),
      .nper(nper), .dcnt(dcnt), .bypass(bypass), .ref_in(ref_in),
      .out_en(out_en), .q(q_out[2*s +: 2])
    );
  end
endmodule

// File: rtl/skm_checker.sv
module skm_checker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  test_sel,
  input logic        ref_in,
  input logic [15:0] func_sel,
  input logic [7:0]  q_out,
  input logic        out_en
);
  p_pair_same_r6: assert property (@(posedge clk) disable iff (rst)
    (q_out[0] == q_out[1]) && (q_out[2] == q_out[3]) &&
    (q_out[4] == q_out[5]) && (q_out[6] == q_out[7]));

  p_hold_low_r9: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (q_out == 8'h00));

  p_bypass_follow_r7: assert property (@(posedge clk) disable iff (rst)
    $past(out_en && (test_sel != 2'b00)) |-> (q_out[0] == $past(ref_in)));

  p_inv_opposite_r5: assert property (@(posedge clk) disable iff (rst)
    $past(out_en && (test_sel == 2'b00) && (func_sel[15:12] == 4'hA) &&
          (func_sel[7:4] == 4'h5) && (func_sel[3:0] == 4'h5))
    |-> ((q_out[6] != q_out[0]) && (q_out[6] != q_out[2])));

  p_div_fall_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(q_out[4]) && $past(out_en) && $past(out_en, 2) &&
     ($past(func_sel[11:8]) == 4'hA) && ($past(func_sel[15:12]) == 4'h0))
    |-> $fell(q_out[6]));
endmodule

bind skew_clk_matrix skm_checker u_chk (
  .clk(clk), .rst(rst), .test_sel(test_sel), .ref_in(ref_in),
  .func_sel(func_sel), .q_out(q_out), .out_en(out_en)
);

// File: tb/skew_clk_matrix_test.sv
module skew_clk_matrix_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  range_sel = 2'b00;
  logic [1:0]  test_sel = 2'b00;
  logic        ref_in = 1'b0;
  logic [15:0] func_sel = 16'h5555;
  logic [7:0]  q_out;

  always #10 clk = ~clk;

  skew_clk_matrix uut (
    .clk(clk), .rst(rst), .range_sel(range_sel), .test_sel(test_sel),
    .ref_in(ref_in), .func_sel(func_sel), .q_out(q_out)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R9";

  // reference model state
  int m_ph, m_dc, m_h, m_key, m_refq;
  logic [7:0] exp_q = 8'h00;

  function automatic int lv(input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b10) return 2;
    return 1;
  endfunction

  function automatic int per_of(input logic [1:0] c);
    case (lv(c))
      0: return 44;
      2: return 16;
      default: return 26;
    endcase
  endfunction

  function automatic logic sec_bit(input int s, input int idx, input int ph,
                                   input int dc, input int n, input bit byp,
                                   input logic rf);
    int   sh;
    int   kind; // 0 shifted, 1 div2, 2 div4, 3 inverted
    logic nominal;
    kind = 0;
    if (s < 2) sh = idx - 4;
    else if (idx == 0) begin kind = 1; sh = 0; end
    else if (idx == 8) begin kind = (s == 2) ? 2 : 3; sh = 0; end
    else sh = 2 * (idx - 4);
    nominal = byp ? rf : (((((ph - sh) % n) + n) % n) < n / 2);
    case (kind)
      1: return logic'(dc % 2);
      2: return logic'((dc / 2) % 2);
      3: return !nominal;
      default: return nominal;
    endcase
  endfunction

  always @(posedge clk) begin : ref_model
    int key, n;
    bit byp, rise;
    key = lv(range_sel);
    for (int s = 0; s < 4; s++)
      key = key * 9 + lv(func_sel[4*s+2 +: 2]) * 3 + lv(func_sel[4*s +: 2]);
    n = per_of(range_sel);
    if (rst) begin
      m_ph = 0; m_dc = 0; m_h = 0; m_key = key; m_refq = 0; exp_q = 8'h00;
    end else if (key != m_key) begin
      m_ph = 0; m_dc = 0; m_h = 0; m_key = key; exp_q = 8'h00;
      m_refq = int'(ref_in);
    end else begin
      byp = (lv(test_sel) != 0);
      if (m_h == n) begin
        for (int s = 0; s < 4; s++) begin
          logic b;
          b = sec_bit(s, lv(func_sel[4*s+2 +: 2]) * 3 + lv(func_sel[4*s +: 2]),
                      m_ph, m_dc, n, byp, ref_in);
          exp_q[2*s]   = b;
          exp_q[2*s+1] = b;
        end
      end else begin
        exp_q = 8'h00;
      end
      rise = ref_in && (m_refq == 0);
      if (byp ? rise : (m_ph == n - 1)) m_dc = (m_dc + 1) % 4;
      m_ph   = (m_ph + 1) % n;
      if (m_h < n) m_h++;
      m_refq = int'(ref_in);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_chk++;
      if (q_out !== exp_q) begin
        n_fail++;
        $display("FAIL %s: q_out actual=%b expected=%b at %0t", cur_req, q_out, exp_q, $time);
      end
      n_chk++;
      if ((q_out[0] !== q_out[1]) || (q_out[2] !== q_out[3]) ||
          (q_out[4] !== q_out[5]) || (q_out[6] !== q_out[7])) begin
        n_fail++;
        $display("FAIL R6: pair mismatch actual=%b expected=equal pairs", q_out);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R1: measure period and high time of q_out[0] directly
  task automatic measure(input string req, input int expp);
    int per, hi;
    per = 0; hi = 0;
    while (!(q_out[0] == 1'b1)) tick(1);
    while (q_out[0] == 1'b1) tick(1);
    while (q_out[0] == 1'b0) tick(1);
    while (q_out[0] == 1'b1) begin tick(1); per++; hi++; end
    while (q_out[0] == 1'b0) begin tick(1); per++; end
    check_eq(req, per, expp);
    check_eq(req, hi, expp / 2);
  endtask

  initial begin
    tick(3);
    cmp_on = 1'b1;
    tick(2);
    rst = 1'b0;
    cur_req = "R9";
    tick(44);
    check_eq("R9", int'(q_out), 0);
    cur_req = "R1";
    measure("R1", 44);
    range_sel = 2'b01; tick(1);
    measure("R1", 26);
    range_sel = 2'b10; tick(1);
    measure("R1", 16);
    cur_req = "R10";
    range_sel = 2'b11; tick(1);
    measure("R10", 26);
    range_sel = 2'b01; tick(30);
    range_sel = 2'b11; tick(30);

    cur_req = "R2";
    range_sel = 2'b10;
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 16; c++) begin
        func_sel = 16'h5555;
        func_sel[4*s +: 4] = 4'(c);
        tick(60);
      end

    for (int s = 2; s < 4; s++)
      for (int c = 0; c < 16; c++) begin
        cur_req = (c == 0) ? "R4" : (c == 10) ? ((s == 2) ? "R4" : "R5") : "R3";
        func_sel = 16'h5555;
        func_sel[4*s +: 4] = 4'(c);
        tick(90);
      end

    cur_req = "R4";
    func_sel = 16'h0A19; range_sel = 2'b00;
    tick(400);
    cur_req = "R5";
    func_sel = 16'hA055;
    tick(150);

    cur_req = "R7";
    func_sel = 16'hA0C6;
    test_sel = 2'b01;
    for (int i = 0; i < 300; i++) begin
      ref_in = logic'((i / (1 + i % 3)) % 2);
      tick(1);
    end
    cur_req = "R8";
    test_sel = 2'b11;
    for (int i = 0; i < 300; i++) begin
      ref_in = logic'((i % 7) < 3);
      tick(1);
    end
    test_sel = 2'b10;
    for (int i = 0; i < 200; i++) begin
      ref_in = ~ref_in;
      tick(1);
    end
    ref_in = 1'b0;
    test_sel = 2'b00;
    tick(100);

    cur_req = "R9";
    func_sel = 16'hA095; tick(20);
    func_sel = 16'hA096; tick(3);
    check_eq("R9", int'(q_out), 0);
    tick(60);
    rst = 1'b1; tick(3);
    check_eq("R9", int'(q_out), 0);
    rst = 1'b0; tick(100);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R9: watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule